// File: doc/BRIEF.md
# SPI Register-Access Slave Frontend

This block lets an external SPI master (clock polarity and phase both zero) read and write a 32-bit, word-addressed register space. The three SPI pins pass through a two-flop synchroniser, and the system clock oversamples them. Every transaction starts with a 32-bit command header, sent most significant bit first. The header carries the direction, a word count and a start address. Data words of 32 bits follow. On a write, each completed word becomes one write strobe on a simple parallel register bus. On a read, each word is fetched with a read strobe and shifted out on MISO.

The register address steps by one after every word, so a single header can cover a run of consecutive registers. A single-cycle snapshot pulse is raised at a fixed protocol instant, so an attached time counter can be sampled or loaded in step with the serial traffic. For a read, that instant is the last header bit. For a write, it is the last bit of each data word.

Top module: `spi_reg_frontend`

## Requirements
- R1: Header bit 31 selects the direction (1 = write, 0 = read), bits 30:25 hold the read word count, and bits 24:4 hold the 21-bit word address. Bits 3:0 have no effect.
- R2: A read returns the number of words given by the count field, with a count of 0 treated as 1. The words come from consecutive addresses, MSB first on MISO, and the first bit is valid at the first SCK rising edge after the header.
- R3: On a write, every completed 32-bit data word produces exactly one write strobe carrying that word (first bit received = bit 31). The count field has no effect on writes.
- R4: After every read or write strobe, the register address increases by one, wrapping modulo 2^21.
- R5: A write transaction produces at most 64 write strobes. Further data words are ignored.
- R6: Raising chip select partway through a word, header or data, ends the transaction without any strobe for that word. The next header is decoded from its first bit.
- R7: A read transaction produces exactly one snapshot pulse, in the same cycle as the read strobe that follows the last header bit.
- R8: On a write, a snapshot pulse accompanies each write strobe, that is, the last bit of each data word.
- R9: Read and write strobes last one cycle, are never high together, and hold the address steady while they are high.
- R10: MISO is low during writes, once a read's word count is used up, and while chip select is high.
- R11: After reset, both strobes, the snapshot pulse and MISO are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 21 | Word address of the current access |
| reg_wdata | output | 32 | Write data, valid with reg_wr_en |
| reg_rdata | input | 32 | Read data, valid in the cycle reg_rd_en is high |
| ts_snap | output | 1 | Time-counter snapshot pulse |

## Verification
The assertions assume the master changes chip select only while SCK is low. They also assume SCK spends at least five system clocks in each phase, so that a word reload or MISO shift has finished before the next SCK edge. Finally, they assume a read strobe is answered by the register file in the same cycle. The stimulus respects all three: it holds each SCK phase for six clocks, asserts and releases chip select with SCK low and with a gap of six or more clocks, and models the register file as a combinational function of the address. Under these conditions the assertions check strobe exclusivity, address stepping, snapshot placement, and silence on every output while chip select has been high longer than the synchroniser lag.

// File: rtl/spi_reg_pkg.sv
// Package: shared widths, header layout and phase encoding for the SPI
// register-access frontend. Assumes a fixed 32-bit header layout.
package spi_reg_pkg;
    localparam int WORD_W  = 32;
    localparam int HDR_W   = 32;
    localparam int ADDR_W  = 21;
    localparam int COUNT_W = 6;
    localparam int ADDR_LO = 4;
    localparam int ADDR_HI = ADDR_LO + ADDR_W - 1;
    localparam int CNT_LO  = ADDR_HI + 1;
    localparam int CNT_HI  = CNT_LO + COUNT_W - 1;
    localparam int DIR_BIT = HDR_W - 1;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_WR,
        PH_RD,
        PH_END
    } phase_t;

    typedef struct packed {
        logic               is_write;
        logic [COUNT_W-1:0] more_words;
        logic [ADDR_W-1:0]  addr;
    } cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-bit two-or-more-flop synchroniser for the SPI pins.
// Assumes each bit is an independent slow asynchronous level.
module spi_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin value through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{rst_val[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_cmd_decode.sv
// Module: splits a received header into direction, extra word count and
// start address. The reserved low nibble is never presented to it.
module spi_cmd_decode
    import spi_reg_pkg::*;
(
    input  logic [HDR_W-1:ADDR_LO] hdr_bits,
    output cmd_t                   cmd
);
    logic [COUNT_W-1:0] cnt_field;

    // Extract fields; a zero count means one word, so extra words = 0.
    always_comb begin
        cnt_field      = hdr_bits[CNT_HI:CNT_LO];
        cmd.is_write   = hdr_bits[DIR_BIT];
        cmd.addr       = hdr_bits[ADDR_HI:ADDR_LO];
        cmd.more_words = (cnt_field == '0) ? '0 : cnt_field - 1'b1;
    end
endmodule

// File: rtl/spi_reg_frontend.sv
// Module: SPI mode-0 slave that turns command headers into register bus
// strobes. Assumes SCK is slow enough that each SCK phase lasts at least
// five clk cycles, and that reg_rdata answers reg_rd_en in the same cycle.
module spi_reg_frontend
    import spi_reg_pkg::*;
#(
    parameter int MAX_WORDS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              ts_snap
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WCNT_W = $clog2(MAX_WORDS + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [WCNT_W-1:0] LAST_WR  = WCNT_W'(MAX_WORDS - 1);

    logic [2:0]          pins_s;
    logic                sck_s, cs_s, mosi_s, sck_q;
    logic                sck_rise, sck_fall, word_end;
    logic [WORD_W-1:0]   rx_sh, rx_word, tx_sh;
    logic [BIT_W-1:0]    bit_cnt;
    logic [WCNT_W-1:0]   wr_cnt;
    logic [COUNT_W-1:0]  rd_left;
    logic [ADDR_W-1:0]   cur_addr;
    logic                shift_pend;
    phase_t              phase;
    cmd_t                cmd;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       ({spi_sck, spi_cs_n, spi_mosi}),
        .rst_val (3'b010),
        .q       (pins_s)
    );

    assign sck_s    = pins_s[2];
    assign cs_s     = pins_s[1];
    assign mosi_s   = pins_s[0];
    assign sck_rise = sck_s & ~sck_q & ~cs_s;
    assign sck_fall = ~sck_s & sck_q & ~cs_s;
    assign rx_word  = {rx_sh[WORD_W-2:0], mosi_s};
    assign word_end = sck_rise && (bit_cnt == LAST_BIT);

    spi_cmd_decode u_dec (
        .hdr_bits (rx_word[HDR_W-1:ADDR_LO]),
        .cmd      (cmd)
    );

    // Remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Transaction engine: header capture, word strobes, MISO shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_HDR;
            rx_sh      <= '0;
            tx_sh      <= '0;
            bit_cnt    <= '0;
            wr_cnt     <= '0;
            rd_left    <= '0;
            cur_addr   <= '0;
            shift_pend <= 1'b0;
            reg_rd_en  <= 1'b0;
            reg_wr_en  <= 1'b0;
            reg_wdata  <= '0;
            ts_snap    <= 1'b0;
        end else begin
            reg_rd_en <= 1'b0;
            reg_wr_en <= 1'b0;
            ts_snap   <= 1'b0;
            if (reg_rd_en) tx_sh <= reg_rdata;
            if (reg_rd_en || reg_wr_en) cur_addr <= cur_addr + 1'b1;
            if (cs_s) begin
                phase      <= PH_HDR;
                bit_cnt    <= '0;
                wr_cnt     <= '0;
                shift_pend <= 1'b0;
                tx_sh      <= '0;
            end else begin
                if (sck_fall && shift_pend) begin
                    tx_sh      <= {tx_sh[WORD_W-2:0], 1'b0};
                    shift_pend <= 1'b0;
                end
                if (sck_rise) begin
                    rx_sh   <= rx_word;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (phase == PH_RD && !word_end) shift_pend <= 1'b1;
                end
                if (word_end) begin
                    unique case (phase)
                        PH_HDR: begin
                            cur_addr <= cmd.addr;
                            if (cmd.is_write) begin
                                phase <= PH_WR;
                            end else begin
                                phase     <= PH_RD;
                                reg_rd_en <= 1'b1;
                                ts_snap   <= 1'b1;
                                rd_left   <= cmd.more_words;
                            end
                        end
                        PH_WR: begin
                            reg_wr_en <= 1'b1;
                            ts_snap   <= 1'b1;
                            reg_wdata <= rx_word;
                            wr_cnt    <= wr_cnt + 1'b1;
                            if (wr_cnt == LAST_WR) phase <= PH_END;
                        end
                        PH_RD: begin
                            if (rd_left != '0) begin
                                reg_rd_en <= 1'b1;
                                rd_left   <= rd_left - 1'b1;
                            end else begin
                                phase <= PH_END;
                                tx_sh <= '0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign reg_addr = cur_addr;
    assign spi_miso = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_reg_frontend_chk.sv
// Module: property checker for spi_reg_frontend, bound to every instance.
// Assumes chip select changes only while SCK is low.
module spi_reg_frontend_chk
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              reg_rd_en,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              ts_snap
);
    localparam int LAG = SYNC_STAGES + 2;
    localparam int RUN_W = $clog2(LAG + 2);
    logic [RUN_W-1:0] cs_run;

    // Count how long chip select has been high, saturating past the lag.
    always_ff @(posedge clk) begin
        if (!rst_n)             cs_run <= '0;
        else if (!spi_cs_n)     cs_run <= '0;
        else if (cs_run < LAG)  cs_run <= cs_run + 1'b1;
    end

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));
    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || reg_wr_en) |=> (reg_addr == $past(reg_addr) + 1'b1));
    assert_snap_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ts_snap |-> (reg_rd_en || reg_wr_en));
    assert_wr_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ts_snap);
    assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_run == RUN_W'(LAG)) |-> !spi_miso);
    assert_quiet_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_run == RUN_W'(LAG)) |-> !(reg_rd_en || reg_wr_en || ts_snap));
endmodule

bind spi_reg_frontend spi_reg_frontend_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .ts_snap   (ts_snap)
);

// File: tb/spi_reg_frontend_test.sv
`timescale 1ns/1ps
// Bench: SPI master model sweeping read counts, write lengths, addresses
// near the wrap point, the 64-word cap and chip-select aborts.
module spi_reg_frontend_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        reg_rd_en, reg_wr_en, ts_snap;
    logic [20:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int vectors = 0;
    int errors = 0;
    int wr_n, rd_n, snap_n;
    logic [20:0] wr_a [0:127];
    logic [31:0] wr_d [0:127];
    logic [20:0] rd_a [0:127];
    logic [31:0] rx_w [0:127];

    always #4 clk = ~clk;

    spi_reg_frontend uut (
        .clk (clk), .rst_n (rst_n), .spi_sck (spi_sck), .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi), .spi_miso (spi_miso), .reg_rd_en (reg_rd_en),
        .reg_wr_en (reg_wr_en), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .ts_snap (ts_snap)
    );

    function automatic logic [31:0] reg_model(input logic [20:0] a);
        return (32'h9E3779B9 * {11'b0, a}) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] wdata_of(input logic [31:0] seed, input int w);
        return seed ^ (32'(w) * 32'h01000193);
    endfunction

    assign reg_rdata = reg_model(reg_addr);

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en && wr_n < 128) begin
                wr_a[wr_n] = reg_addr; wr_d[wr_n] = reg_wdata; wr_n++;
            end
            if (reg_rd_en && rd_n < 128) begin
                rd_a[rd_n] = reg_addr; rd_n++;
            end
            if (ts_snap) snap_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic r);
        spi_sck = 1'b0; spi_mosi = b;
        repeat (6) @(negedge clk);
        r = spi_miso; spi_sck = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] hdr, input int hdr_bits, input int nwords,
                        input int extra_bits, input logic [31:0] seed);
        logic r;
        logic [31:0] d;
        wr_n = 0; rd_n = 0; snap_n = 0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 31; i >= 32 - hdr_bits; i--) send_bit(hdr[i], r);
        for (int w = 0; w < nwords; w++) begin
            d = wdata_of(seed, w);
            for (int b = 31; b >= 0; b--) begin
                send_bit(d[b], r);
                if (w < 128) rx_w[w][b] = r;
            end
        end
        for (int e = 0; e < extra_bits; e++) send_bit(1'b1, r);
        spi_sck = 1'b0;
        repeat (6) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic read_case(input int cnt, input logic [20:0] addr, input logic [3:0] rsv);
        int eff;
        logic [20:0] a;
        eff = (cnt == 0) ? 1 : cnt;
        xfer({1'b0, 6'(cnt), addr, rsv}, 32, eff + 1, 0, 32'h0);
        check(rd_n == eff, "R2 read strobe count", 32'(rd_n), 32'(eff));
        check(wr_n == 0, "R1 read makes no write", 32'(wr_n), 32'h0);
        check(snap_n == 1, "R7 one snapshot per read", 32'(snap_n), 32'h1);
        for (int i = 0; i < eff; i++) begin
            a = addr + 21'(i);
            check(rd_a[i] == a, "R4 read address step (R1 decode)", 32'(rd_a[i]), 32'(a));
            check(rx_w[i] == reg_model(a), "R2 MISO read word", rx_w[i], reg_model(a));
        end
        check(rx_w[eff] == 32'h0, "R10 MISO after count", rx_w[eff], 32'h0);
    endtask

    task automatic write_case(input int n, input logic [20:0] addr, input logic [5:0] cnt,
                              input logic [31:0] seed);
        int expn;
        logic [20:0] a;
        expn = (n > 64) ? 64 : n;
        xfer({1'b1, cnt, addr, 4'h5}, 32, n, 0, seed);
        check(wr_n == expn, "R3 R5 write strobe count", 32'(wr_n), 32'(expn));
        check(rd_n == 0, "R1 write makes no read", 32'(rd_n), 32'h0);
        check(snap_n == expn, "R8 snapshot per write word", 32'(snap_n), 32'(expn));
        for (int i = 0; i < expn; i++) begin
            a = addr + 21'(i);
            check(wr_a[i] == a, "R4 write address step", 32'(wr_a[i]), 32'(a));
            check(wr_d[i] == wdata_of(seed, i), "R3 write data", wr_d[i], wdata_of(seed, i));
        end
        check(rx_w[0] == 32'h0, "R10 MISO low in write", rx_w[0], 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check({reg_rd_en, reg_wr_en, ts_snap, spi_miso} == 4'b0, "R11 in reset",
              {28'h0, reg_rd_en, reg_wr_en, ts_snap, spi_miso}, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({reg_rd_en, reg_wr_en, ts_snap, spi_miso} == 4'b0, "R11 after reset",
              {28'h0, reg_rd_en, reg_wr_en, ts_snap, spi_miso}, 32'h0);

        foreach (rd_a[k]) rd_a[k] = '0;
        for (int c = 0; c < 6; c++) begin
            if (c == 4) continue;
            read_case(c, 21'h000010, 4'hA);
            read_case(c, 21'h1FFFFE, 4'hF);
            read_case(c, 21'h0ABCDE, 4'h0);
        end
        read_case(63, 21'h1FFFF0, 4'h3);

        for (int n = 1; n <= 4; n++) begin
            write_case(n, 21'h000100, 6'(n * 7), 32'hC0DE0000 + 32'(n));
            write_case(n, 21'h1FFFFD, 6'h3F, 32'h13572468);
        end
        write_case(66, 21'h000040, 6'h00, 32'hFEEDF00D);

        // R6: abort mid data word after two full words.
        xfer({1'b1, 6'h0, 21'h000200, 4'h0}, 32, 2, 13, 32'hABCD0000);
        check(wr_n == 2, "R6 partial write word dropped", 32'(wr_n), 32'h2);
        // R6: abort inside the header.
        xfer({1'b0, 6'h2, 21'h000300, 4'h0}, 20, 0, 0, 32'h0);
        check(rd_n + wr_n + snap_n == 0, "R6 partial header no strobe",
              32'(rd_n + wr_n + snap_n), 32'h0);
        // R6: next header realigned after abort.
        read_case(2, 21'h000777, 4'h9);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule